// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Port

This block is an eight-bit, full-duplex synchronous serial port. A control register selects whether it runs as bus master or as bus slave. As master, it divides the system clock down to a serial clock and drives the data-out line. As slave, it takes the serial clock and an active-low select from outside and drives the data-in line of the remote master. In both roles a single shift engine moves one byte out and one byte in at the same time, most significant bit first. Clock polarity and phase are programmable. Both ends of a link must be set to the same polarity and phase.

Software uses the port through five small registers on a simple strobe bus: a 16-bit control word, a read-only status byte, an 8-bit divider, a write-only transmit byte and a read-only receive byte. The port also has a 3-bit core-divider input. Any setting above 1 holds the port idle.

Top module: `spi_port`

## Requirements
- R1: One transfer moves exactly 8 bits out and 8 bits in at the same time, most significant bit first, on both data lines.
- R2: In master mode one transfer is exactly eight SCLK periods, which is 16 SCLK edges, after which SCLK rests.
- R3: In master mode each SCLK half-period lasts (1 + DIV) system clocks, so f_SCLK = f_clk / (2 × (1 + DIV)).
- R4: In master mode sclk_oe and mosi_oe are high and miso_oe is low. In slave mode sclk_oe and mosi_oe are low, and miso_oe is high only while select is low.
- R5: In slave mode a transfer starts when select falls, and bytes keep shifting while select stays low. Raising select mid-byte abandons that byte, and no receive data is posted. Slave SCLK half-periods must last at least 4 system clocks.
- R6: With CPHA = 0 data is sampled on the leading edge (the edge leaving the idle level) and launched on the trailing edge. With CPHA = 1 it is launched on the leading edge and sampled on the trailing edge. The idle SCLK level equals CPOL.
- R7: Register addresses are 0 control, 1 status, 2 divider, 3 transmit, 4 receive. Control bit 0 is enable, bit 1 is master, bit 2 is CPOL and bit 3 is CPHA. Control bits 15:4 read as zero.
- R8: When core_div is greater than 1, the port performs no transfer and enables no output.
- R9: Status bit 0 (transmit empty) is 1 after reset. A transmit write clears it, and it sets again when the byte is loaded into the shift engine.
- R10: Status bit 1 (receive valid) sets when a byte completes, and reading the receive register clears it. Status bit 2 (overflow) sets when a byte completes while bit 1 is still set, and the same read clears it.
- R11: In master mode, writing the transmit register while idle starts a transfer within two system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_div | input | 3 | Core clock divider setting; values above 1 hold the port idle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed to clear receive status) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| sclk_i | input | 1 | Serial clock from an external master |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Output enable for sclk_o |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Master-to-slave data, used in slave mode |
| mosi_o | output | 1 | Master-to-slave data, driven in master mode |
| mosi_oe | output | 1 | Output enable for mosi_o |
| miso_i | input | 1 | Slave-to-master data, used in master mode |
| miso_o | output | 1 | Slave-to-master data, driven in slave mode |
| miso_oe | output | 1 | Output enable for miso_o |

## Verification
The properties assume that core_div is steady enough to be sampled on the system clock. They also assume that, in slave mode, mosi_i holds its value for the three-clock latency between a real SCLK edge and its synchronised image. That latency holds only if every slave SCLK half-period lasts at least four system clocks. The stimulus links two copies of the port back to back and uses divider values of 3 and above, so the slave sees half-periods of four clocks or more. Select is raised mid-byte only in the one test that checks the abandon rule.

// File: rtl/spi_port_pkg.sv
// Shared constants for the dual-role serial port: register addresses and
// bit positions inside the control and status words.
package spi_port_pkg;

    typedef enum logic [2:0] {
        ADDR_CTRL = 3'd0,
        ADDR_STAT = 3'd1,
        ADDR_DIV  = 3'd2,
        ADDR_TX   = 3'd3,
        ADDR_RX   = 3'd4
    } spi_addr_e;

    localparam int CTL_EN   = 0;
    localparam int CTL_MST  = 1;
    localparam int CTL_CPOL = 2;
    localparam int CTL_CPHA = 3;
    localparam int CTL_W    = 4;

    localparam int ST_TXE = 0;
    localparam int ST_RXV = 1;
    localparam int ST_OVF = 2;

endpackage

// File: rtl/spi_sync.sv
// Two-flop synchroniser with edge detection, one lane per bit.
// Assumes each input level is held for at least two system clocks.
module spi_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar g = 0; g < W; g++) begin : g_lane
        logic s1, s2, s3;
        // Metastability chain plus one history flop for the edge detector.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= rst_val[g];
                s2 <= rst_val[g];
                s3 <= rst_val[g];
            end else begin
                s1 <= d[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign lvl[g]  = s2;
        assign rise[g] = s2 & ~s3;
        assign fall[g] = ~s2 & s3;
    end
endmodule

// File: rtl/spi_clkgen.sv
// Master serial clock generator. While run is high it fires one edge every
// (div + 1) system clocks and toggles the phase; it flags the last of EDGES
// edges. Phase 0 is the idle level; the edge leaving it is a leading edge.
module spi_clkgen #(
    parameter int DIV_W = 8,
    parameter int EDGES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             edge_o,
    output logic             lead_o,
    output logic             last_o,
    output logic             phase_o
);
    localparam int EW = $clog2(EDGES);

    logic [DIV_W-1:0] cnt;
    logic [EW-1:0]    nedge;
    logic             ph;

    // Half-period counter, edge counter and phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            nedge <= '0;
            ph    <= 1'b0;
        end else if (cnt == div) begin
            cnt   <= '0;
            nedge <= (nedge == EW'(EDGES - 1)) ? '0 : nedge + 1'b1;
            ph    <= ~ph;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign edge_o  = run && (cnt == div);
    assign lead_o  = ~ph;
    assign last_o  = edge_o && (nedge == EW'(EDGES - 1));
    assign phase_o = ph;
endmodule

// File: rtl/spi_shift.sv
// Byte shift engine shared by both roles. Transmit data leaves from the MSB.
// Receive bits enter at the LSB on sample strobes. A launch shifts the
// transmit register only if a sample came before it, so the first launch
// in phase-1 mode keeps the MSB on the line. done pulses on the W-th sample,
// and rx_byte is valid in that same cycle.
module spi_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    input  logic         sample,
    input  logic         launch,
    input  logic         sdi,
    output logic         sdo,
    output logic         done,
    output logic [W-1:0] rx_byte
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  txsh, rxsh;
    logic [CW-1:0] bitn;
    logic          pend;

    // Load, abandon, or shift on the strobes from the active role.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txsh <= '0;
            rxsh <= '0;
            bitn <= '0;
            pend <= 1'b0;
        end else if (load) begin
            txsh <= load_val;
            bitn <= '0;
            pend <= 1'b0;
        end else if (clear) begin
            bitn <= '0;
            pend <= 1'b0;
        end else begin
            if (sample) begin
                rxsh <= {rxsh[W-2:0], sdi};
                pend <= 1'b1;
                bitn <= (bitn == CW'(W - 1)) ? '0 : bitn + 1'b1;
            end
            if (launch && pend) begin
                txsh <= {txsh[W-2:0], 1'b0};
                pend <= 1'b0;
            end
        end
    end

    assign sdo     = txsh[W-1];
    assign done    = sample && !clear && (bitn == CW'(W - 1));
    assign rx_byte = {rxsh[W-2:0], sdi};
endmodule

// File: rtl/spi_port.sv
// Dual-role serial port top. Holds the registers and picks the strobe
// source for the shared shift engine: the internal clock generator in master
// mode, or the synchronised external SCLK and select in slave mode. Assumes
// slave SCLK half-periods of at least four system clocks.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_W    = 8,
    parameter int CDIV_W   = 3,
    parameter int CDIV_MAX = 1,
    parameter int REG_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CDIV_W-1:0] core_div,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe
);
    localparam int EDGES = 2 * DATA_W;

    logic [CTL_W-1:0]  ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] txbuf, rx_q, rx_byte;
    logic tx_empty, rx_valid, rx_ovf, busy;
    logic active, m_act, s_act, cpol, cpha;
    logic wr_tx, rd_rx, m_start, s_start, s_sel;
    logic ck_edge, ck_lead, ck_last, ck_ph;
    logic [1:0] sy_lvl, sy_rise, sy_fall;
    logic s_lead, s_trail, sample, launch, load, clear, sdi, sdo, sh_done;

    assign cpol   = ctrl_q[CTL_CPOL];
    assign cpha   = ctrl_q[CTL_CPHA];
    assign active = ctrl_q[CTL_EN] && (core_div <= CDIV_W'(CDIV_MAX));
    assign m_act  = active && ctrl_q[CTL_MST];
    assign s_act  = active && !ctrl_q[CTL_MST];
    assign wr_tx  = reg_wr && (reg_addr == ADDR_TX);
    assign rd_rx  = reg_rd && (reg_addr == ADDR_RX);

    spi_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ss_n_i, sclk_i}), .rst_val(2'b10),
        .lvl(sy_lvl), .rise(sy_rise), .fall(sy_fall)
    );

    spi_clkgen #(.DIV_W(DIV_W), .EDGES(EDGES)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
        .edge_o(ck_edge), .lead_o(ck_lead), .last_o(ck_last), .phase_o(ck_ph)
    );

    assign s_sel   = s_act && !sy_lvl[1];
    assign s_start = s_act && sy_fall[1];
    assign s_lead  = cpol ? sy_fall[0] : sy_rise[0];
    assign s_trail = cpol ? sy_rise[0] : sy_fall[0];
    assign m_start = m_act && !busy && !tx_empty && !wr_tx;

    // Strobe selection: phase 0 samples on leading edges, phase 1 on trailing.
    always_comb begin
        if (m_act) begin
            sample = ck_edge && (ck_lead != cpha);
            launch = ck_edge && (ck_lead == cpha);
            clear  = !busy;
            sdi    = miso_i;
        end else begin
            sample = s_sel && (cpha ? s_trail : s_lead);
            launch = s_sel && (cpha ? s_lead : s_trail);
            clear  = !s_sel;
            sdi    = mosi_i;
        end
    end

    assign load = m_start || s_start || (s_sel && sh_done);

    spi_shift #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(txbuf),
        .clear(clear), .sample(sample), .launch(launch), .sdi(sdi),
        .sdo(sdo), .done(sh_done), .rx_byte(rx_byte)
    );

    // Control and divider register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else if (reg_wr && reg_addr == ADDR_CTRL) begin
            ctrl_q <= reg_wdata[CTL_W-1:0];
        end else if (reg_wr && reg_addr == ADDR_DIV) begin
            div_q <= reg_wdata[DIV_W-1:0];
        end
    end

    // Transmit buffer and its empty flag; a software write takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txbuf    <= '0;
            tx_empty <= 1'b1;
        end else if (wr_tx) begin
            txbuf    <= reg_wdata[DATA_W-1:0];
            tx_empty <= 1'b0;
        end else if (load) begin
            tx_empty <= 1'b1;
        end
    end

    // Master transfer-in-progress flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !m_act) busy <= 1'b0;
        else if (m_start)     busy <= 1'b1;
        else if (ck_last)     busy <= 1'b0;
    end

    // Receive register, valid and overflow flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q     <= '0;
            rx_valid <= 1'b0;
            rx_ovf   <= 1'b0;
        end else if (sh_done) begin
            rx_q     <= rx_byte;
            rx_valid <= 1'b1;
            rx_ovf   <= (rx_ovf || rx_valid) && !rd_rx;
        end else if (rd_rx) begin
            rx_valid <= 1'b0;
            rx_ovf   <= 1'b0;
        end
    end

    // Read-data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {{(REG_W-CTL_W){1'b0}}, ctrl_q};
            ADDR_STAT: reg_rdata = {{(REG_W-3){1'b0}}, rx_ovf, rx_valid, tx_empty};
            ADDR_DIV:  reg_rdata = {{(REG_W-DIV_W){1'b0}}, div_q};
            ADDR_RX:   reg_rdata = {{(REG_W-DATA_W){1'b0}}, rx_q};
            default:   reg_rdata = '0;
        endcase
    end

    assign sclk_o  = cpol ^ ck_ph;
    assign sclk_oe = m_act;
    assign mosi_o  = sdo;
    assign mosi_oe = m_act;
    assign miso_o  = sdo;
    assign miso_oe = s_sel;
endmodule

// File: rtl/spi_port_chk.sv
// Property checker for spi_port, attached through bind. Watches pin
// enables, idle clock level, gating and the status flag rules.
module spi_port_chk #(
    parameter int CDIV_W   = 3,
    parameter int CDIV_MAX = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CDIV_W-1:0] core_div,
    input logic              sclk_o,
    input logic              sclk_oe,
    input logic              mosi_oe,
    input logic              miso_oe,
    input logic              cpol,
    input logic              busy,
    input logic              tx_empty,
    input logic              rx_valid,
    input logic              rx_ovf,
    input logic              wr_tx,
    input logic              rd_rx,
    input logic              done
);
    p_dir_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mosi_oe |-> (!miso_oe && sclk_oe));

    p_gate_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_div > CDIV_W'(CDIV_MAX)) |-> (!sclk_oe && !mosi_oe && !miso_oe));

    p_gate_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_div > CDIV_W'(CDIV_MAX)) |=> !busy);

    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_oe && !busy) |-> (sclk_o == cpol));

    p_txw_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> !tx_empty);

    p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !done) |=> (!rx_valid && !rx_ovf));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovf) |-> $past(rx_valid));
endmodule

bind spi_port spi_port_chk #(.CDIV_W(CDIV_W), .CDIV_MAX(CDIV_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .core_div(core_div), .sclk_o(sclk_o),
    .sclk_oe(sclk_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe),
    .cpol(ctrl_q[2]), .busy(busy), .tx_empty(tx_empty),
    .rx_valid(rx_valid), .rx_ovf(rx_ovf), .wr_tx(wr_tx),
    .rd_rx(rd_rx), .done(sh_done)
);

// File: tb/spi_port_tb.sv
// Bench: two ports linked back to back, one as master (u_dut) and one as
// slave (u_slv). A vector table drives mode/divider/data combinations, then
// directed tests cover reset, gating, overflow, select abort and registers.
module spi_port_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [2:0]  m_cd = '0, s_cd = '0;
    logic        m_wr = 0, m_rd = 0, s_wr = 0, s_rd = 0;
    logic [2:0]  m_addr = '0, s_addr = '0;
    logic [15:0] m_wdata = '0, s_wdata = '0, m_rdata, s_rdata;
    logic        ss_n = 1'b1;
    logic m_sclk, m_sclk_oe, m_mosi, m_mosi_oe, m_miso_unused, m_miso_oe;
    logic s_sclk_unused, s_sclk_oe, s_mosi_unused, s_mosi_oe, s_miso, s_miso_oe;

    spi_port u_dut (
        .clk(clk), .rst_n(rst_n), .core_div(m_cd),
        .reg_wr(m_wr), .reg_rd(m_rd), .reg_addr(m_addr),
        .reg_wdata(m_wdata), .reg_rdata(m_rdata),
        .sclk_i(1'b0), .sclk_o(m_sclk), .sclk_oe(m_sclk_oe),
        .ss_n_i(1'b1), .mosi_i(1'b0), .mosi_o(m_mosi), .mosi_oe(m_mosi_oe),
        .miso_i(s_miso), .miso_o(m_miso_unused), .miso_oe(m_miso_oe)
    );

    spi_port u_slv (
        .clk(clk), .rst_n(rst_n), .core_div(s_cd),
        .reg_wr(s_wr), .reg_rd(s_rd), .reg_addr(s_addr),
        .reg_wdata(s_wdata), .reg_rdata(s_rdata),
        .sclk_i(m_sclk), .sclk_o(s_sclk_unused), .sclk_oe(s_sclk_oe),
        .ss_n_i(ss_n), .mosi_i(m_mosi), .mosi_o(s_mosi_unused), .mosi_oe(s_mosi_oe),
        .miso_i(1'b0), .miso_o(s_miso), .miso_oe(s_miso_oe)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    logic cur_cpol = 0, cur_cpha = 0;

    // Bus monitor on the master clock: counts edges, high-phase clocks and
    // rebuilds the MOSI byte MSB-first from the sample edges.
    int unsigned mon_edges = 0, act_cnt = 0;
    logic [7:0] mon_byte = '0;
    always @(m_sclk) begin
        mon_edges = mon_edges + 1;
        if ((m_sclk != cur_cpol) == !cur_cpha)
            mon_byte = {mon_byte[6:0], m_mosi};
    end
    always @(posedge clk) if (m_sclk != cur_cpol) act_cnt = act_cnt + 1;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input bit sl, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        if (sl) begin s_wr = 1; s_addr = a; s_wdata = d; end
        else    begin m_wr = 1; m_addr = a; m_wdata = d; end
        @(negedge clk);
        s_wr = 0; m_wr = 0;
    endtask

    task automatic rd(input bit sl, input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        if (sl) begin s_rd = 1; s_addr = a; end
        else    begin m_rd = 1; m_addr = a; end
        #1;
        d = sl ? s_rdata : m_rdata;
        @(negedge clk);
        s_rd = 0; m_rd = 0;
    endtask

    task automatic setup(input logic pol, input logic pha, input logic [7:0] dv);
        wr(0, 3'd0, {12'h0, pha, pol, 2'b11});
        wr(0, 3'd2, {8'h0, dv});
        wr(1, 3'd0, {12'h0, pha, pol, 2'b01});
        cur_cpol = pol; cur_cpha = pha;
        repeat (2) @(negedge clk);
    endtask

    // Vector fields: [25] CPOL, [24] CPHA, [23:16] divider, [15:8] master byte, [7:0] slave byte.
    localparam logic [25:0] VEC [0:4] = '{
        {1'b0, 1'b0, 8'd3, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 8'd4, 8'h81, 8'h7E},
        {1'b1, 1'b0, 8'd5, 8'h0F, 8'hF0},
        {1'b1, 1'b1, 8'd3, 8'hD2, 8'h4B},
        {1'b0, 1'b0, 8'd7, 8'hFF, 8'h00}
    };

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int unsigned e0, a0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state: R9 transmit empty, R7 control zero, R4 no enables.
        rd(0, 3'd1, d); check("R9 reset status", d, 16'h0001);
        rd(0, 3'd0, d); check("R7 reset ctrl", d, 16'h0000);
        check("R4 reset sclk_oe", {15'h0, m_sclk_oe}, 16'h0);
        check("R4 reset miso_oe", {15'h0, s_miso_oe}, 16'h0);

        // R7: reserved control bits read zero.
        wr(0, 3'd0, 16'hFFFF);
        rd(0, 3'd0, d); check("R7 reserved bits", d, 16'h000F);

        for (int i = 0; i < 5; i++) begin
            logic [7:0] dv, mtx, stx;
            dv = VEC[i][23:16]; mtx = VEC[i][15:8]; stx = VEC[i][7:0];
            setup(VEC[i][25], VEC[i][24], dv);
            check("R6 idle level", {15'h0, m_sclk}, {15'h0, VEC[i][25]});
            wr(1, 3'd3, {8'h0, stx});
            ss_n = 0;
            repeat (4) @(negedge clk);
            check("R4 slave drives miso", {13'h0, s_miso_oe, s_sclk_oe, s_mosi_oe}, 16'h0004);
            check("R4 master pins", {13'h0, m_sclk_oe, m_mosi_oe, m_miso_oe}, 16'h0006);
            e0 = mon_edges; a0 = act_cnt;
            wr(0, 3'd3, {8'h0, mtx});
            repeat (16 * (int'(dv) + 1) + 12) @(negedge clk);
            ss_n = 1;
            repeat (4) @(negedge clk);
            check("R1 mosi MSB first", {8'h0, mon_byte}, {8'h0, mtx});
            check("R2 sclk edges", 16'(mon_edges - e0), 16'd16);
            check("R3 half-period length", 16'(act_cnt - a0), 16'(8 * (int'(dv) + 1)));
            rd(0, 3'd1, d); check("R10 master status", d, 16'h0003);
            rd(0, 3'd4, d); check("R1 master rx", d, {8'h0, stx});
            rd(1, 3'd4, d); check("R5 slave rx", d, {8'h0, mtx});
            rd(0, 3'd1, d); check("R10 valid cleared", d, 16'h0001);
        end

        // R11: a transmit write while idle starts at once.
        setup(0, 0, 8'd3);
        wr(0, 3'd3, 16'h0033);
        rd(0, 3'd1, d); check("R11 start loads buffer", d, 16'h0001);
        repeat (80) @(negedge clk);
        // R10: second completion without a read sets overflow.
        wr(0, 3'd3, 16'h0044);
        repeat (80) @(negedge clk);
        rd(0, 3'd1, d); check("R10 overflow set", d, 16'h0007);
        rd(0, 3'd4, d);
        rd(0, 3'd1, d); check("R10 read clears overflow", d, 16'h0001);

        // R8: core divider above 1 holds the port idle.
        m_cd = 3'd2;
        e0 = mon_edges;
        wr(0, 3'd3, 16'h0055);
        repeat (80) @(negedge clk);
        check("R8 no sclk edges", 16'(mon_edges - e0), 16'd0);
        check("R8 no enables", {15'h0, m_sclk_oe}, 16'h0);
        rd(0, 3'd1, d); check("R8 nothing consumed", d, 16'h0000);
        m_cd = 3'd1;
        repeat (80) @(negedge clk);
        rd(0, 3'd1, d); check("R8 resumes at setting 1", d, 16'h0003);
        rd(0, 3'd4, d);

        // R5: raising select mid-byte abandons the slave byte.
        wr(1, 3'd3, 16'h0081);
        ss_n = 0;
        repeat (4) @(negedge clk);
        wr(0, 3'd3, 16'h005A);
        repeat (30) @(negedge clk);
        ss_n = 1;
        repeat (60) @(negedge clk);
        rd(1, 3'd1, d); check("R5 abort posts nothing", d, 16'h0001);
        rd(0, 3'd4, d);
        wr(1, 3'd3, 16'h0096);
        ss_n = 0;
        repeat (4) @(negedge clk);
        wr(0, 3'd3, 16'h00C3);
        repeat (80) @(negedge clk);
        ss_n = 1;
        repeat (4) @(negedge clk);
        rd(1, 3'd4, d); check("R5 restart slave rx", d, 16'h00C3);
        rd(0, 3'd4, d); check("R1 restart master rx", d, 16'h0096);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule